// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each and delivers the full `2*WIDTH`-bit product. It takes one multiplier bit per clock. The multiplier is parked in the low half of a double-width accumulator. When the accumulator's least significant bit is set, the multiplicand is added into the upper half. The accumulator, together with the adder's carry-out, then moves one place to the right. Each bit that crosses into the low half is final and is never added to again. As the multiplier bits are used up, the low half fills with result bits.

A caller drives the two operands and a one-cycle `start` pulse while the unit is not busy. `busy` stays high for exactly `WIDTH` clocks. `done` then rises together with a valid `product`. The product and `done` hold their values until the next accepted start. A start that arrives during a run is ignored.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is all zeros.
- R2: A `start` sampled high at a rising edge while `busy` is low captures both operands. From that edge on, `busy` is 1 and `done` is 0.
- R3: If `start` is accepted at edge n, `busy` stays 1 through edge n+WIDTH-1. At edge n+WIDTH, `busy` falls and `done` rises. `busy` and `done` are never high together.
- R4: When `done` rises, `product` equals the unsigned product of the captured multiplicand and multiplier, over all `2*WIDTH` bits.
- R5: The carry out of each WIDTH-bit addition is kept and enters the product's top bit in the same step. Both operands at all ones give (2^WIDTH-1)^2.
- R6: A `start` pulse while `busy` is high has no effect. Neither the finishing edge nor the result changes, even when the operand inputs carry other values.
- R7: While no new start is accepted, `done` stays 1 and `product` stays unchanged, whatever the operand inputs do.
- R8: A zero operand gives a zero product. When the true product fits in WIDTH bits, the upper half of `product` is zero.
- R9: A `start` presented in the same cycle in which `done` is high begins a new run at once, with the R3 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiplication (honoured only when not busy) |
| multiplicand | input | WIDTH | Operand added into the upper half |
| multiplier | input | WIDTH | Operand whose bits are consumed one per clock |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | `product` holds a finished result |
| product | output | 2*WIDTH | Full unsigned product |

## Verification
The unit is driven with several kinds of operands, and each kind exposes a different fault.
- Small operands whose product fits in the low half show a wrong shift direction or a non-zero upper half.
- All-ones operands show a dropped adder carry.
- Single-bit operands at the lowest and highest positions show a step count that is off by one, or a lost last step.
- Zero operands show an addition that is not gated by the multiplier bit.
- Mixed pseudo-random values cover the general case.

A reference model in the bench predicts `busy`, `done` and `product` on every clock. Further runs place a start pulse in the middle of a run, hold the unit idle while the operand inputs change, and issue a new start in the same cycle that `done` is high.

// File: rtl/mul_pkg.sv
package mul_pkg;

    // Sequencer states of the shift-add multiplier
    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_RUN  = 2'd1,
        MS_DONE = 2'd2
    } mul_state_e;

endpackage

// File: rtl/mul_step.sv
// One iteration: conditional add into the upper half, then a right shift
// that takes in the adder carry.
module mul_step #(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0]   mcand,
    output logic [2*WIDTH-1:0] acc_out
);
    localparam int ACC_W = 2 * WIDTH;

    logic [WIDTH-1:0] addend;
    logic [WIDTH:0]   upper_sum;

    always_comb begin
        addend    = acc_in[0] ? mcand : '0;
        upper_sum = {1'b0, acc_in[ACC_W-1:WIDTH]} + {1'b0, addend};
        acc_out   = {upper_sum, acc_in[WIDTH-1:1]};
    end

    // R4: with a clear multiplier bit the step is a plain right shift
    always_comb begin
        if (!$isunknown(acc_in) && !acc_in[0]) begin
            a_r4_skip_add: assert (acc_out == (acc_in >> 1));
        end
    end

endmodule

// File: rtl/mul_seq.sv
// Sequencer: accepts start when idle, counts WIDTH steps, flags done.
module mul_seq
    import mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] STEPS = CNT_W'(WIDTH);

    typedef struct packed {
        mul_state_e       st;
        logic [CNT_W-1:0] left;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        load  = 1'b0;
        step  = 1'b0;
        case (seq_q.st)
            MS_IDLE, MS_DONE: begin
                if (start) begin
                    seq_d.st   = MS_RUN;
                    seq_d.left = STEPS;
                    load       = 1'b1;
                end
            end
            MS_RUN: begin
                step       = 1'b1;
                seq_d.left = seq_q.left - 1'b1;
                if (seq_q.left == 1) begin
                    seq_d.st = MS_DONE;
                end
            end
            default: seq_d.st = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= MS_IDLE;
            seq_q.left <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.st == MS_RUN);
    assign done = (seq_q.st == MS_DONE);

    a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    a_r3_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seq_q.left > 1) |=> (busy && seq_q.left == $past(seq_q.left) - 1'b1));

endmodule

// File: rtl/shift_add_mul.sv
// Unsigned sequential multiplier, one multiplier bit per clock.
module shift_add_mul #(
    parameter int WIDTH = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WIDTH-1:0]     multiplicand,
    input  logic [WIDTH-1:0]     multiplier,
    output logic                 busy,
    output logic                 done,
    output logic [2*WIDTH-1:0]   product
);
    localparam int ACC_W = 2 * WIDTH;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [WIDTH-1:0] mcand;
    } dp_t;

    dp_t dp_d, dp_q;

    logic             load;
    logic             step;
    logic [ACC_W-1:0] acc_next;

    mul_seq #(.WIDTH(WIDTH)) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    mul_step #(.WIDTH(WIDTH)) step_i (
        .acc_in  (dp_q.acc),
        .mcand   (dp_q.mcand),
        .acc_out (acc_next)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.acc   = {{WIDTH{1'b0}}, multiplier};
            dp_d.mcand = multiplicand;
        end else if (step) begin
            dp_d.acc = acc_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q.acc   <= '0;
            dp_q.mcand <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign product = dp_q.acc;

    a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(product)));

    a_r6_operands_kept: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dp_q.mcand));

    a_r8_zero_mcand: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && dp_q.mcand == '0) |-> (product == '0));

    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && !done && product == '0));

endmodule

// File: tb/shift_add_mul_tb_top.sv
module shift_add_mul_tb_top;
    localparam int W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [W-1:0]     mcand = '0;
    logic [W-1:0]     mplier = '0;
    logic             busy;
    logic             done;
    logic [2*W-1:0]   product;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    shift_add_mul #(.WIDTH(W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (mcand),
        .multiplier   (mplier),
        .busy         (busy),
        .done         (done),
        .product      (product)
    );

    // Behavioural reference model
    int             m_left = 0;
    bit             m_busy = 1'b0;
    bit             m_done = 1'b0;
    bit             m_known = 1'b1;
    logic [2*W-1:0] m_pend = '0;
    logic [2*W-1:0] m_prod = '0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (!m_busy && start) begin
                m_busy  = 1'b1;
                m_done  = 1'b0;
                m_known = 1'b0;
                m_left  = W;
                m_pend  = {{W{1'b0}}, mcand} * {{W{1'b0}}, mplier};
            end else if (m_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy  = 1'b0;
                    m_done  = 1'b1;
                    m_known = 1'b1;
                    m_prod  = m_pend;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy == m_busy, "R3 busy", 64'(busy), 64'(m_busy));
            check(done == m_done, "R3 done", 64'(done), 64'(m_done));
            if (m_known) check(product == m_prod, "R4 product", product, m_prod);
        end
    end

    // Runs one multiplication; optional intruding start at step 'poke_at'
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                           input int poke_at, input string tag);
        logic [2*W-1:0] exp;
        exp = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R2 busy after start", {busy, done}, 2'b10);
        for (int i = 1; i < W; i++) begin
            if (i == poke_at) begin
                mcand = ~a; mplier = b ^ 32'h5A5A_0F0F; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
        end
        check(busy && !done, "R3 still busy at last step", {busy, done}, 2'b10);
        @(negedge clk);
        check(!busy && done, "R3 done on time", {busy, done}, 2'b01);
        check(product == exp, tag, product, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && product == '0, "R1 reset state", product, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && product == '0, "R1 idle after reset", product, '0);

        run_mul(32'd7, 32'd9, 0, "R8 small product");
        check(product[2*W-1:W] == '0, "R8 upper half zero", product, 64'd63);
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R5 all ones carry");
        run_mul(32'h8000_0000, 32'h8000_0000, 0, "R4 top bits");
        run_mul(32'd1, 32'h0000_0001, 0, "R4 unit");
        run_mul(32'd0, 32'hDEAD_BEEF, 0, "R8 zero multiplicand");
        run_mul(32'h1234_5678, 32'd0, 0, "R8 zero multiplier");
        run_mul(32'h89AB_CDEF, 32'h0F1E_2D3C, 0, "R4 mixed");
        // Start same cycle done is high (back-to-back)
        run_mul(32'hCAFE_F00D, 32'h7654_3210, 0, "R9 back-to-back");
        // Start mid-run must be ignored
        run_mul(32'h0BAD_C0DE, 32'h0000_FFFF, 5, "R6 ignored start");
        run_mul(32'hFFFF_0001, 32'h8000_0001, W - 1, "R6 late ignored start");
        for (int k = 0; k < 6; k++) begin
            run_mul($urandom(), $urandom(), 0, "R4 random");
        end

        // Hold: operands move, no start
        begin
            logic [2*W-1:0] held;
            held = product;
            for (int i = 0; i < 6; i++) begin
                mcand = $urandom(); mplier = $urandom();
                @(negedge clk);
            end
            check(done && product == held, "R7 result held", product, held);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule